// File: doc/BRIEF.md
# Prescaled Compare Timer

This block is a free-running up-counter with a programmable prescaler. It compares the count against a period value and two compare values, and drives a single output pin from those matches. A 4-bit mode code picks the pin behaviour. The pin can stay inactive while the block works as a plain timer, or it can be set, cleared or toggled on a primary match. It can also form a pulse that rises on the primary match and falls on the secondary match. In one of the pulse modes, new compare values are held back until the period wraps.

The counter runs 16 bits wide by default. The width select joins it into one 32-bit time base. The period and compare values are then used at full width instead of only their low halves. A one-cycle pulse marks every period wrap, and another marks every primary match. While the block is disabled, the counter and prescaler are held at zero and the outputs are held low.

Top module: `cmp_timer`

## Requirements
- R1: While reset is asserted and after it is released with the block disabled, `pin_o`, `match_o` and `roll_o` are all 0.
- R2: Prescale code `psc_i` 0, 1, 2 and 3 advances the counter once every 1, 4, 16 and 64 clock cycles respectively.
- R3: The counter steps from 0 up to the period value and then returns to 0. `roll_o` is high for one cycle after each return, so consecutive `roll_o` pulses are (period+1)×ratio cycles apart.
- R4: With `wide_i`=0, only bits 15:0 of the period and compare values are used. With `wide_i`=1, all 32 bits are used.
- R5: Mode 4'b0000 keeps `pin_o` at 0 while the counter and `roll_o` keep running.
- R6: Mode 4'b0001 sets `pin_o` to 1 when the count equals compare A. In every mode from 4'b0000 to 4'b0101, each such primary match gives exactly one `match_o` pulse per period.
- R7: Mode 4'b0010 clears `pin_o` to 0 on a compare A match and never raises it.
- R8: Mode 4'b0011 inverts `pin_o` on each compare A match, so each high phase lasts (period+1)×ratio cycles.
- R9: Mode 4'b0100 raises `pin_o` on a compare A match and lowers it on a compare B match, giving a high time of (B−A)×ratio cycles. Compare writes take effect at once. When A equals B, the lowering wins and the pin stays 0.
- R10: In mode 4'b0101, the pin behaves as in R9, but compare writes land in shadow registers. Those are copied into the working compare values only when the counter wraps.
- R11: Mode codes 4'b0110 through 4'b1111 are unsupported and drive `pin_o` to 0 from the next cycle on.
- R12: With `en_i`=0, the outputs are 0 from the next cycle and the counter and prescaler return to zero. After re-enabling, the first `roll_o` comes (period+1)×ratio cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable |
| mode_i | input | 4 | Pin behaviour code |
| wide_i | input | 1 | 1 = 32-bit time base, 0 = 16-bit |
| psc_i | input | 2 | Prescale code |
| period_i | input | 32 | Terminal count of the counter |
| cmp_a_we_i | input | 1 | Write strobe for compare A |
| cmp_a_wd_i | input | 32 | Write data for compare A |
| cmp_b_we_i | input | 1 | Write strobe for compare B |
| cmp_b_wd_i | input | 32 | Write data for compare B |
| pin_o | output | 1 | Compare output pin |
| match_o | output | 1 | One-cycle pulse on a compare A match |
| roll_o | output | 1 | One-cycle pulse on a period wrap |

## Verification
The pin is driven by each mode in turn over the same period and compare settings. Set, clear and toggle are told apart by the pin level after a wrap and by the length of the high phase. Dual-edge high widths are measured before and after a mid-period write to compare B. Because the same write shows up one period later in buffered mode and at once in unbuffered mode, the width tells the two modes apart. Time from enable to the first wrap is measured for all four prescale codes. A period value with bits set above bit 15 is timed in both widths to expose the 16-bit masking. The pin is first driven high and then switched to a reserved code or disabled, so a missing force to low would be visible.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int MODE_W     = 4;
  localparam int PSC_CODE_W = 2;
  localparam int PSC_CNT_W  = 2 * ((1 << PSC_CODE_W) - 1);

  typedef enum logic [MODE_W-1:0] {
    MD_TIMER   = 4'b0000,
    MD_SET     = 4'b0001,
    MD_CLR     = 4'b0010,
    MD_TGL     = 4'b0011,
    MD_DUAL    = 4'b0100,
    MD_DUALBUF = 4'b0101
  } cmp_mode_e;

  // Terminal value of the prescale counter: ratio minus one.
  function automatic logic [PSC_CNT_W-1:0] psc_limit(input logic [PSC_CODE_W-1:0] code);
    logic [PSC_CNT_W:0] full;
    full = ({{PSC_CNT_W{1'b0}}, 1'b1} << {code, 1'b0}) - 1'b1;
    return full[PSC_CNT_W-1:0];
  endfunction

  function automatic logic mode_known(input logic [MODE_W-1:0] m);
    return (m <= MD_DUALBUF);
  endfunction

endpackage

// File: rtl/cmp_timer_psc.sv
module cmp_timer_psc
  import cmp_timer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_i,
  input  logic [PSC_CODE_W-1:0] code_i,
  output logic                  tick_o
);

  logic [PSC_CNT_W-1:0] div_q;
  logic [PSC_CNT_W-1:0] div_d;

  always_comb begin
    tick_o = run_i && (div_q >= psc_limit(code_i));
    div_d  = div_q;
    if (!run_i) begin
      div_d = '0;
    end else if (tick_o) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/cmp_timer_base.sv
module cmp_timer_base #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic [TW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          roll_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic          roll_q;

  always_comb begin
    wrap_o = tick_i && (cnt_q >= limit_i);
    cnt_d  = cnt_q;
    if (!run_i) begin
      cnt_d = '0;
    end else if (wrap_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      roll_q <= wrap_o;
    end
  end

  assign cnt_o  = cnt_q;
  assign roll_o = roll_q;

endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs #(
  parameter int TW  = 32,
  parameter int NCH = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   hold_i,
  input  logic                   load_i,
  input  logic [NCH-1:0]         we_i,
  input  logic [NCH-1:0][TW-1:0] wd_i,
  output logic [NCH-1:0][TW-1:0] act_o
);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [TW-1:0] shd_q, shd_d;
    logic [TW-1:0] act_q, act_d;

    always_comb begin
      shd_d = we_i[g] ? wd_i[g] : shd_q;
      act_d = act_q;
      if (hold_i) begin
        if (load_i) begin
          act_d = shd_q;
        end
      end else if (we_i[g]) begin
        act_d = wd_i[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_q <= '0;
        act_q <= '0;
      end else begin
        shd_q <= shd_d;
        act_q <= act_d;
      end
    end

    assign act_o[g] = act_q;
  end

endmodule

// File: rtl/cmp_timer_out.sv
module cmp_timer_out
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              hit_a_i,
  input  logic              hit_b_i,
  output logic              pin_o,
  output logic              match_o
);

  logic pin_q, pin_d;
  logic match_q, match_d;

  always_comb begin
    pin_d = 1'b0;
    if (run_i) begin
      case (mode_i)
        MD_SET:  pin_d = hit_a_i ? 1'b1 : pin_q;
        MD_CLR:  pin_d = hit_a_i ? 1'b0 : pin_q;
        MD_TGL:  pin_d = hit_a_i ? ~pin_q : pin_q;
        MD_DUAL, MD_DUALBUF: begin
          if (hit_b_i) begin
            pin_d = 1'b0;
          end else if (hit_a_i) begin
            pin_d = 1'b1;
          end else begin
            pin_d = pin_q;
          end
        end
        default: pin_d = 1'b0;
      endcase
    end
    match_d = run_i && mode_known(mode_i) && hit_a_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      pin_q   <= pin_d;
      match_q <= match_d;
    end
  end

  assign pin_o   = pin_q;
  assign match_o = match_q;

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic [MODE_W-1:0]     mode_i,
  input  logic                  wide_i,
  input  logic [PSC_CODE_W-1:0] psc_i,
  input  logic [TW-1:0]         period_i,
  input  logic                  cmp_a_we_i,
  input  logic [TW-1:0]         cmp_a_wd_i,
  input  logic                  cmp_b_we_i,
  input  logic [TW-1:0]         cmp_b_wd_i,
  output logic                  pin_o,
  output logic                  match_o,
  output logic                  roll_o
);

  localparam int HW  = TW / 2;
  localparam int NCH = 2;

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  function automatic logic [TW-1:0] fit(input logic [TW-1:0] v, input logic w);
    return w ? v : {{(TW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  logic                   tick_w;
  logic                   wrap_w;
  logic [TW-1:0]          cnt_w;
  logic [TW-1:0]          lim_w;
  logic [NCH-1:0]         we_w;
  logic [NCH-1:0][TW-1:0] wd_w;
  logic [NCH-1:0][TW-1:0] act_w;
  logic [NCH-1:0]         hit_w;
  logic                   buf_w;

  assign lim_w = fit(period_i, wide_i);
  assign we_w  = {cmp_b_we_i, cmp_a_we_i};
  assign wd_w  = {cmp_b_wd_i, cmp_a_wd_i};
  assign buf_w = (mode_i == MD_DUALBUF);

  for (genvar g = 0; g < NCH; g++) begin : g_hit
    assign hit_w[g] = tick_w && (cnt_w == fit(act_w[g], wide_i));
  end

  cmp_timer_psc psc_i0 (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (en_i),
    .code_i (psc_i),
    .tick_o (tick_w)
  );

  cmp_timer_base #(.TW(TW)) base_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (en_i),
    .tick_i  (tick_w),
    .limit_i (lim_w),
    .cnt_o   (cnt_w),
    .wrap_o  (wrap_w),
    .roll_o  (roll_o)
  );

  cmp_timer_regs #(.TW(TW), .NCH(NCH)) regs_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .hold_i (buf_w),
    .load_i (wrap_w),
    .we_i   (we_w),
    .wd_i   (wd_w),
    .act_o  (act_w)
  );

  cmp_timer_out out_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run_i   (en_i),
    .mode_i  (mode_i),
    .hit_a_i (hit_w[0]),
    .hit_b_i (hit_w[1]),
    .pin_o   (pin_o),
    .match_o (match_o)
  );

endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_i,
  input logic [3:0]    mode_i,
  input logic          pin_o,
  input logic          match_o,
  input logic          roll_o,
  input logic          wrap_i,
  input logic [TW-1:0] act_b_i
);

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!pin_o && !match_o && !roll_o)); // R12

  AST_TIMER_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == 4'b0000) |=> !pin_o); // R5

  AST_UNSUPPORTED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i > 4'b0101) |=> !pin_o); // R11

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == 4'b0001 && pin_o) |=> pin_o); // R6

  AST_CLEAR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == 4'b0010) |=> !$rose(pin_o)); // R7

  AST_SHADOW_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 4'b0101 && !wrap_i) |=> $stable(act_b_i)); // R10

  AST_ROLL_AFTER_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    roll_o |-> $past(wrap_i)); // R3

endmodule

bind cmp_timer cmp_timer_chk #(.TW(TW)) chk_i (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .en_i    (en_i),
  .mode_i  (mode_i),
  .pin_o   (pin_o),
  .match_o (match_o),
  .roll_o  (roll_o),
  .wrap_i  (wrap_w),
  .act_b_i (act_w[1])
);

// File: tb/cmp_timer_tb_top.sv
module cmp_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_i;
  logic [3:0]  mode_i;
  logic        wide_i;
  logic [1:0]  psc_i;
  logic [31:0] period_i;
  logic        cmp_a_we_i, cmp_b_we_i;
  logic [31:0] cmp_a_wd_i, cmp_b_wd_i;
  logic        pin_o, match_o, roll_o;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i), .wide_i(wide_i),
    .psc_i(psc_i), .period_i(period_i),
    .cmp_a_we_i(cmp_a_we_i), .cmp_a_wd_i(cmp_a_wd_i),
    .cmp_b_we_i(cmp_b_we_i), .cmp_b_wd_i(cmp_b_wd_i),
    .pin_o(pin_o), .match_o(match_o), .roll_o(roll_o)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_a(input logic [31:0] v);
    @(negedge clk); cmp_a_wd_i = v; cmp_a_we_i = 1'b1;
    @(negedge clk); cmp_a_we_i = 1'b0;
  endtask

  task automatic wr_b(input logic [31:0] v);
    @(negedge clk); cmp_b_wd_i = v; cmp_b_we_i = 1'b1;
    @(negedge clk); cmp_b_we_i = 1'b0;
  endtask

  task automatic wait_roll();
    int n = 0;
    do begin @(negedge clk); n++; end while (!roll_o && n < 70000);
  endtask

  // Cycles from re-enable to the first wrap pulse.
  task automatic en_to_roll(output int n);
    @(negedge clk); en_i = 1'b0;
    @(negedge clk); en_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!roll_o && n < 70000);
  endtask

  task automatic roll_gap(output int n);
    wait_roll();
    n = 0;
    do begin @(negedge clk); n++; end while (!roll_o && n < 70000);
  endtask

  task automatic high_width(output int n);
    int w = 0;
    while (!pin_o && w < 3000) begin @(negedge clk); w++; end
    n = 0;
    while (pin_o && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic count_high(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (pin_o) n++; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en_i = 1'b0; mode_i = 4'b0000; wide_i = 1'b0; psc_i = 2'd0;
    period_i = 32'd9; cmp_a_we_i = 1'b0; cmp_b_we_i = 1'b0;
    cmp_a_wd_i = '0; cmp_b_wd_i = '0;
    repeat (3) @(negedge clk);
    chk("R1 outputs in reset", {pin_o, match_o, roll_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 outputs after release", {pin_o, match_o, roll_o}, 0);
  endtask

  task automatic t_prescale();
    int n;
    int hi;
    mode_i = 4'b0000; period_i = 32'd9;
    for (int c = 0; c < 4; c++) begin
      psc_i = c[1:0];
      en_to_roll(n);
      chk($sformatf("R2 enable-to-wrap code %0d", c), n, 10 * (1 << (2 * c)));
    end
    psc_i = 2'd1;
    roll_gap(n);
    chk("R3 wrap spacing ratio 4", n, 40);
    psc_i = 2'd0;
    count_high(30, hi);
    chk("R5 timer mode pin low", hi, 0);
  endtask

  task automatic t_width();
    int n;
    period_i = 32'h0001_0003; psc_i = 2'd0;
    wide_i = 1'b0;
    en_to_roll(n);
    chk("R4 16-bit period", n, 4);
    wide_i = 1'b1;
    en_to_roll(n);
    chk("R4 32-bit period", n, 32'h0001_0004);
    wide_i = 1'b0; period_i = 32'd9;
  endtask

  task automatic t_single();
    int n;
    int m;
    wr_a(32'd3); wr_b(32'd7);
    mode_i = 4'b0001;
    en_to_roll(n);
    wait_roll();
    chk("R6 set mode pin high", pin_o, 1);
    m = 0;
    wait_roll();
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (match_o) m++; end
    chk("R6 one match pulse per period", m, 1);
    mode_i = 4'b0010;
    wait_roll(); wait_roll();
    chk("R7 clear mode pin low", pin_o, 0);
    mode_i = 4'b0011;
    high_width(n);
    chk("R8 toggle high phase ratio 1", n, 10);
    psc_i = 2'd1;
    wait_roll();
    high_width(n);
    chk("R8 toggle high phase ratio 4", n, 40);
    psc_i = 2'd0;
  endtask

  task automatic t_dual();
    int n;
    mode_i = 4'b0100;
    wait_roll(); wait_roll();
    high_width(n);
    chk("R9 dual-edge width", n, 4);
    wait_roll();
    wr_b(32'd9);
    high_width(n);
    chk("R9 unbuffered write immediate", n, 6);
    wr_b(32'd3);
    wait_roll(); wait_roll();
    count_high(20, n);
    chk("R9 equal compares keep pin low", n, 0);
    wr_b(32'd7);
    wait_roll();
  endtask

  task automatic t_buffered();
    int n;
    mode_i = 4'b0101;
    wait_roll();
    wr_b(32'd9);
    high_width(n);
    chk("R10 buffered write deferred", n, 4);
    high_width(n);
    chk("R10 buffered value after wrap", n, 6);
  endtask

  task automatic t_unsupported();
    logic [3:0] codes [3] = '{4'b1000, 4'b1100, 4'b1110};
    int n;
    for (int k = 0; k < 3; k++) begin
      mode_i = 4'b0001;
      wait_roll(); wait_roll();
      chk("R11 pin set before code", pin_o, 1);
      mode_i = codes[k];
      @(negedge clk);
      chk($sformatf("R11 code %b drops pin", codes[k]), pin_o, 0);
      count_high(15, n);
      chk($sformatf("R11 code %b stays low", codes[k]), n, 0);
    end
  endtask

  task automatic t_disable();
    int n;
    mode_i = 4'b0001;
    wait_roll(); wait_roll();
    repeat (2) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    chk("R12 disabled outputs low", {pin_o, match_o, roll_o}, 0);
    repeat (5) @(negedge clk);
    en_i = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!roll_o && n < 1000);
    chk("R12 counter restarts from zero", n, 10);
  endtask

  initial begin
    t_reset();
    en_i = 1'b1;
    t_prescale();
    t_width();
    t_single();
    t_dual();
    t_buffered();
    t_unsupported();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule